// File: doc/BRIEF.md
# DRAM Strobe Cycle Decoder

This block acts as the memory side of an asynchronous extended-data-out DRAM interface. It is used as a synthesizable responder when a DRAM controller is under test. A fast local clock samples the four active-low strobes (row strobe, column strobe, write enable, output enable) through two-flop synchronisers. The block then works out each cycle's type from the order in which the synchronised strobes fall. It latches the row and column from a multiplexed address bus, reads and writes a small internal array of 4-bit words, and decides when the data driver is on. No analog timing is modelled. Every rule is applied on synchronised edges.

The cycle types it recognises are these:
- reads
- early writes
- late writes
- read-modify-write cycles
- several column cycles on one open row
- row-strobe-only refresh
- column-before-row refresh, using an internal row counter
- hidden refresh
- self-refresh, entered after a long refresh pulse

A status port gives the type of the last cycle as a code, together with the current refresh counter. This lets a bench check the refresh sequencing.

The address and data inputs are sampled without synchronisers. They must therefore be stable for at least three clock cycles around each strobe edge that uses them. The array holds 2^(2*ADDR_W) words, with word index {row, column}.

Top module: `dram_strobe_decoder`

## Requirements
- R1: When the row strobe falls while the column strobe is already low, the cycle is a refresh. The address pins are ignored, `rfsh_row_o` increases by one modulo 2^ADDR_W once per such cycle, `cycle_o` becomes 6, and the array is unchanged.
- R2: A row strobe pulse with the column strobe high latches the address as the row. If it ends with no column strobe fall, `cycle_o` becomes 5, and both the counter and the array are unchanged.
- R3: If write enable is low when the column strobe falls, the word at {row, address} takes `dq_i` (early write). `cycle_o` becomes 2 and `dq_oe_o` stays 0 for that column cycle.
- R4: If write enable falls while the column strobe is low and no write has yet happened in that column cycle, the word at the latched column takes `dq_i`. `cycle_o` becomes 4 (read-modify-write) if read data was driven earlier in that column cycle, and 3 (late write) if it was not.
- R5: A column strobe fall with write enable high loads the stored word and sets `cycle_o` to 1. `dq_o` carries that word whenever `dq_oe_o` is 1. The word stays driven after the column strobe rises, until the next column strobe fall.
- R6: `dq_oe_o` is 0 while output enable is high or write enable is low, and from two cycles after both the row and column strobes are seen high.
- R7: With the row strobe held low, successive column cycles on the same row each act on their own as a read, an early write, a late write or a read-modify-write.
- R8: When the row and column strobes fall on the same sampled edge, the cycle is treated as column-first, that is, as a refresh under R1.
- R9: If the row strobe falls with the column strobe low while read data is still held, the cycle is a hidden refresh. `cycle_o` becomes 7, the counter advances as in R1, and the held word keeps being driven.
- R10: A refresh whose row strobe stays low for SELF_CNT clock cycles enters self-refresh, and `cycle_o` becomes 8. The counter advances only once for the whole pulse. Self-refresh ends when the row strobe rises, and normal cycles follow.
- R11: After reset, `dq_oe_o` is 0, `cycle_o` is 0 and `rfsh_row_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ras_ni | input | 1 | Row strobe, active low, asynchronous |
| cas_ni | input | 1 | Column strobe, active low, asynchronous |
| we_ni | input | 1 | Write enable, active low, asynchronous |
| oe_ni | input | 1 | Output enable, active low, asynchronous |
| addr_i | input | ADDR_W | Multiplexed row/column address |
| dq_i | input | DW | Write data |
| dq_o | output | DW | Read data (zero when not driven) |
| dq_oe_o | output | 1 | Data driver enable |
| cycle_o | output | 4 | Last cycle type code (0 none, 1 read, 2 early write, 3 late write, 4 read-modify-write, 5 row-only refresh, 6 counter refresh, 7 hidden refresh, 8 self-refresh) |
| rfsh_row_o | output | ADDR_W | Internal refresh row counter |

## Verification
Suppose the row or column latch captures the wrong address. The first read of the affected word then returns data that differs from the arithmetic pattern written there, within three clocks of the column strobe fall. If the strobe-order logic misclassifies a cycle, `cycle_o` shows the wrong code at the next synchronised edge. In the same cycle the refresh counter steps when it should hold, or holds when it should step. A stuck data-valid flag appears as `dq_oe_o` staying high once both strobes have risen. Self-refresh entry is observed just before and just after the SELF_CNT boundary.

// File: rtl/dsd_pkg.sv
package dsd_pkg;
  typedef enum logic [3:0] {
    CYC_NONE     = 4'd0,
    CYC_READ     = 4'd1,
    CYC_EARLY    = 4'd2,
    CYC_LATE     = 4'd3,
    CYC_RMW      = 4'd4,
    CYC_RAS_ONLY = 4'd5,
    CYC_CBR      = 4'd6,
    CYC_HIDDEN   = 4'd7,
    CYC_SELF     = 4'd8
  } cyc_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ROW,
    ST_RFSH,
    ST_SELF
  } st_e;
endpackage

// File: rtl/dsd_sync.sv
module dsd_sync #(
  parameter int W = 4,
  parameter logic RST_VAL = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic ff1_q, ff2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ff1_q <= RST_VAL;
        ff2_q <= RST_VAL;
      end else begin
        ff1_q <= d_i[i];
        ff2_q <= ff1_q;
      end
    end
    assign q_o[i] = ff2_q;
  end
endmodule

// File: rtl/dsd_array.sv
module dsd_array #(
  parameter int AW = 6,
  parameter int DW = 4
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/dsd_ctrl.sv
module dsd_ctrl
  import dsd_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int DW       = 4,
  parameter int SELF_CNT = 12500
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ras_i,
  input  logic                cas_i,
  input  logic                we_i,
  input  logic                oe_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DW-1:0]       rd_data_i,
  output logic                wr_en_o,
  output logic [2*ADDR_W-1:0] wr_addr_o,
  output logic [2*ADDR_W-1:0] rd_addr_o,
  output logic [DW-1:0]       dout_o,
  output logic                drive_o,
  output cyc_e                cycle_o,
  output logic [ADDR_W-1:0]   rfsh_row_o
);
  localparam int SCW = $clog2(SELF_CNT + 1);

  logic ras_q, cas_q, we_q;
  logic ras_fall, ras_rise, cas_fall, we_fall;
  st_e  st_q;
  cyc_e cyc_q;
  logic [ADDR_W-1:0] row_q, col_q, rcnt_q;
  logic [DW-1:0]     dout_q;
  logic [SCW-1:0]    scnt_q;
  logic valid_q, shown_q, cas_wr_q, cas_seen_q;
  logic in_row, early_wr, late_wr;

  assign ras_fall = ras_i & ~ras_q;
  assign ras_rise = ~ras_i & ras_q;
  assign cas_fall = cas_i & ~cas_q;
  assign we_fall  = we_i & ~we_q;

  assign drive_o  = valid_q & oe_i & ~we_i;
  assign in_row   = (st_q == ST_ROW) & ~ras_rise;
  assign early_wr = in_row & cas_fall & we_i;
  assign late_wr  = in_row & ~cas_fall & we_fall & cas_i & ~cas_wr_q;

  assign wr_en_o    = early_wr | late_wr;
  assign wr_addr_o  = early_wr ? {row_q, addr_i} : {row_q, col_q};
  assign rd_addr_o  = {row_q, addr_i};
  assign dout_o     = dout_q;
  assign cycle_o    = cyc_q;
  assign rfsh_row_o = rcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ras_q      <= 1'b0;
      cas_q      <= 1'b0;
      we_q       <= 1'b0;
      st_q       <= ST_IDLE;
      cyc_q      <= CYC_NONE;
      row_q      <= '0;
      col_q      <= '0;
      rcnt_q     <= '0;
      dout_q     <= '0;
      scnt_q     <= '0;
      valid_q    <= 1'b0;
      shown_q    <= 1'b0;
      cas_wr_q   <= 1'b0;
      cas_seen_q <= 1'b0;
    end else begin
      ras_q <= ras_i;
      cas_q <= cas_i;
      we_q  <= we_i;
      if (drive_o) shown_q <= 1'b1;
      if (!ras_i && !cas_i) valid_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (ras_fall) begin
            if (cas_i) begin
              // column first (or simultaneous): counter refresh
              st_q   <= ST_RFSH;
              rcnt_q <= rcnt_q + 1'b1;
              scnt_q <= '0;
              cyc_q  <= valid_q ? CYC_HIDDEN : CYC_CBR;
            end else begin
              st_q       <= ST_ROW;
              row_q      <= addr_i;
              cas_seen_q <= 1'b0;
            end
          end
        end
        ST_ROW: begin
          if (ras_rise) begin
            st_q <= ST_IDLE;
            if (!cas_seen_q) cyc_q <= CYC_RAS_ONLY;
          end else if (cas_fall) begin
            col_q      <= addr_i;
            cas_seen_q <= 1'b1;
            shown_q    <= 1'b0;
            cas_wr_q   <= we_i;
            if (we_i) begin
              valid_q <= 1'b0;
              cyc_q   <= CYC_EARLY;
            end else begin
              valid_q <= 1'b1;
              dout_q  <= rd_data_i;
              cyc_q   <= CYC_READ;
            end
          end else if (late_wr) begin
            cas_wr_q <= 1'b1;
            valid_q  <= 1'b0;
            cyc_q    <= (shown_q | drive_o) ? CYC_RMW : CYC_LATE;
          end
        end
        ST_RFSH: begin
          if (ras_rise) begin
            st_q <= ST_IDLE;
          end else if (scnt_q == SCW'(SELF_CNT - 1)) begin
            st_q  <= ST_SELF;
            cyc_q <= CYC_SELF;
          end else begin
            scnt_q <= scnt_q + 1'b1;
          end
        end
        ST_SELF: begin
          if (ras_rise) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dram_strobe_decoder.sv
module dram_strobe_decoder
  import dsd_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int DW       = 4,
  parameter int SELF_CNT = 12500
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ras_ni,
  input  logic              cas_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     dq_i,
  output logic [DW-1:0]     dq_o,
  output logic              dq_oe_o,
  output logic [3:0]        cycle_o,
  output logic [ADDR_W-1:0] rfsh_row_o
);
  localparam int AW = 2 * ADDR_W;

  logic [3:0]    strb_n;
  logic          ras_a, cas_a, we_a, oe_a;
  logic          wr_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [DW-1:0] rd_data, dout;
  cyc_e          cyc;

  dsd_sync #(.W(4), .RST_VAL(1'b1)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({ras_ni, cas_ni, we_ni, oe_ni}),
    .q_o    (strb_n)
  );

  assign ras_a = ~strb_n[3];
  assign cas_a = ~strb_n[2];
  assign we_a  = ~strb_n[1];
  assign oe_a  = ~strb_n[0];

  dsd_ctrl #(.ADDR_W(ADDR_W), .DW(DW), .SELF_CNT(SELF_CNT)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ras_i      (ras_a),
    .cas_i      (cas_a),
    .we_i       (we_a),
    .oe_i       (oe_a),
    .addr_i     (addr_i),
    .rd_data_i  (rd_data),
    .wr_en_o    (wr_en),
    .wr_addr_o  (wr_addr),
    .rd_addr_o  (rd_addr),
    .dout_o     (dout),
    .drive_o    (dq_oe_o),
    .cycle_o    (cyc),
    .rfsh_row_o (rfsh_row_o)
  );

  dsd_array #(.AW(AW), .DW(DW)) u_array (
    .clk_i   (clk_i),
    .we_i    (wr_en),
    .waddr_i (wr_addr),
    .wdata_i (dq_i),
    .raddr_i (rd_addr),
    .rdata_o (rd_data)
  );

  assign dq_o    = dq_oe_o ? dout : '0;
  assign cycle_o = cyc;
endmodule

// File: rtl/dsd_checker.sv
module dsd_checker
  import dsd_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ras_a,
  input logic              cas_a,
  input logic              wr_en,
  input logic              dq_oe_o,
  input logic [3:0]        cycle_o,
  input logic [ADDR_W-1:0] rfsh_row_o
);
  AST_RFSH_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ras_a) && cas_a) |=> (rfsh_row_o == ADDR_W'($past(rfsh_row_o) + 1'b1))); // R1

  AST_RFSH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !($rose(ras_a) && cas_a) |=> $stable(rfsh_row_o)); // R1

  AST_EARLY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cycle_o == CYC_EARLY && cas_a) |-> !dq_oe_o); // R3

  AST_WR_STROBES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> (ras_a && cas_a)); // R4

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ras_a && !cas_a && $past(!ras_a && !cas_a)) |-> !dq_oe_o); // R6

  AST_SELF_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cycle_o == CYC_SELF && $past(cycle_o) != CYC_SELF) |-> ras_a); // R10
endmodule

bind dram_strobe_decoder dsd_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ras_a      (ras_a),
  .cas_a      (cas_a),
  .wr_en      (wr_en),
  .dq_oe_o    (dq_oe_o),
  .cycle_o    (cycle_o),
  .rfsh_row_o (rfsh_row_o)
);

// File: tb/sim_dram_strobe_decoder.sv
module sim_dram_strobe_decoder;
  localparam int AWB = 3;
  localparam int SC  = 12500;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AWB-1:0] addr = '0;
  logic [3:0] din = '0;
  logic [3:0] dq;
  logic dq_oe;
  logic [3:0] cyc;
  logic [AWB-1:0] rrow;

  int nchk = 0;
  int nerr = 0;
  logic [3:0] mem_exp [64];
  int rc;

  always #4 clk = ~clk;

  dram_strobe_decoder #(.ADDR_W(AWB), .DW(4), .SELF_CNT(SC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ras_ni(ras_n), .cas_ni(cas_n),
    .we_ni(we_n), .oe_ni(oe_n), .addr_i(addr), .dq_i(din),
    .dq_o(dq), .dq_oe_o(dq_oe), .cycle_o(cyc), .rfsh_row_o(rrow)
  );

  function automatic logic [3:0] pat(int r, int c);
    return 4'((r * 5 + c * 3 + 7) & 15);
  endfunction

  task automatic wt();
    repeat (5) @(negedge clk);
  endtask

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic read_cell(string req, int r, int c);
    addr = AWB'(r); ras_n = 1'b0; wt();
    addr = AWB'(c); oe_n = 1'b0; cas_n = 1'b0; wt();
    chk(req, "read drive", 32'(dq_oe), 1);
    chk(req, "read data", 32'(dq), 32'(mem_exp[r*8+c]));
    cas_n = 1'b1; oe_n = 1'b1; ras_n = 1'b1; wt();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (6) @(negedge clk);
    rst_n = 1'b1;
    wt();
    chk("R11", "oe after reset", 32'(dq_oe), 0);
    chk("R11", "cycle after reset", 32'(cyc), 0);
    chk("R11", "counter after reset", 32'(rrow), 0);

    // R3 R7: early-write sweep, page mode over every column
    for (int r = 0; r < 8; r++) begin
      addr = AWB'(r); ras_n = 1'b0; wt();
      for (int c = 0; c < 8; c++) begin
        addr = AWB'(c); din = pat(r, c); we_n = 1'b0; oe_n = 1'b0; wt();
        cas_n = 1'b0; wt();
        chk("R3", "early write hi-z", 32'(dq_oe), 0);
        chk("R3", "early write code", 32'(cyc), 2);
        mem_exp[r*8+c] = pat(r, c);
        cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; wt();
      end
      ras_n = 1'b1; wt();
    end

    // R5 R7: read sweep with EDO hold after the column strobe rises
    for (int r = 0; r < 8; r++) begin
      addr = AWB'(r); ras_n = 1'b0; oe_n = 1'b0; wt();
      for (int c = 0; c < 8; c++) begin
        addr = AWB'(c); cas_n = 1'b0; wt();
        chk("R5", "read drive", 32'(dq_oe), 1);
        chk("R7", "page read data", 32'(dq), 32'(pat(r, c)));
        chk("R5", "read code", 32'(cyc), 1);
        cas_n = 1'b1; wt();
        chk("R5", "held after cas rise", 32'(dq), 32'(pat(r, c)));
        chk("R5", "held drive", 32'(dq_oe), 1);
      end
      ras_n = 1'b1; wt();
      chk("R6", "off with both strobes high", 32'(dq_oe), 0);
      oe_n = 1'b1;
    end

    // R6: output enable and write enable gating
    addr = 3'd1; ras_n = 1'b0; wt();
    addr = 3'd2; oe_n = 1'b0; cas_n = 1'b0; wt();
    chk("R6", "driven before gating", 32'(dq_oe), 1);
    oe_n = 1'b1; wt();
    chk("R6", "off with oe high", 32'(dq_oe), 0);
    oe_n = 1'b0; wt();
    cas_n = 1'b1; wt();
    we_n = 1'b0; wt();
    chk("R6", "off with we low", 32'(dq_oe), 0);
    we_n = 1'b1; wt();
    chk("R6", "back on after we high", 32'(dq), 32'(pat(1, 2)));
    ras_n = 1'b1; oe_n = 1'b1; wt();
    read_cell("R6", 1, 2);

    // R4: late write, no data shown
    addr = 3'd3; ras_n = 1'b0; wt();
    addr = 3'd4; cas_n = 1'b0; wt();
    addr = 3'd0; din = 4'd9; we_n = 1'b0; wt();
    chk("R4", "late write code", 32'(cyc), 3);
    chk("R4", "late write hi-z", 32'(dq_oe), 0);
    mem_exp[3*8+4] = 4'd9;
    cas_n = 1'b1; we_n = 1'b1; ras_n = 1'b1; wt();
    read_cell("R4", 3, 4);
    read_cell("R4", 3, 0);

    // R4: read-modify-write
    addr = 3'd5; ras_n = 1'b0; wt();
    addr = 3'd6; oe_n = 1'b0; cas_n = 1'b0; wt();
    chk("R4", "rmw read part", 32'(dq), 32'(pat(5, 6)));
    oe_n = 1'b1; wt();
    din = 4'd2; we_n = 1'b0; wt();
    chk("R4", "rmw code", 32'(cyc), 4);
    mem_exp[5*8+6] = 4'd2;
    cas_n = 1'b1; we_n = 1'b1; ras_n = 1'b1; wt();
    read_cell("R4", 5, 6);

    // R7: mixed page: read, early write, read back in one row
    addr = 3'd6; ras_n = 1'b0; wt();
    addr = 3'd1; oe_n = 1'b0; cas_n = 1'b0; wt();
    chk("R7", "mixed page read", 32'(dq), 32'(mem_exp[6*8+1]));
    cas_n = 1'b1; oe_n = 1'b1; wt();
    din = 4'd15; we_n = 1'b0; wt();
    cas_n = 1'b0; wt();
    chk("R7", "mixed page write code", 32'(cyc), 2);
    mem_exp[6*8+1] = 4'd15;
    cas_n = 1'b1; we_n = 1'b1; wt();
    oe_n = 1'b0; cas_n = 1'b0; wt();
    chk("R7", "mixed page read back", 32'(dq), 15);
    cas_n = 1'b1; oe_n = 1'b1; ras_n = 1'b1; wt();

    // R2: row-only refresh
    rc = int'(rrow);
    addr = 3'd7; ras_n = 1'b0; wt();
    ras_n = 1'b1; wt();
    chk("R2", "row-only code", 32'(cyc), 5);
    chk("R2", "row-only counter hold", 32'(rrow), 32'(rc));
    read_cell("R2", 7, 0);

    // R1: counter refresh, full wrap, address ignored
    rc = int'(rrow);
    for (int i = 0; i < 8; i++) begin
      cas_n = 1'b0; wt();
      addr = AWB'(7 - i); ras_n = 1'b0; wt();
      chk("R1", "refresh code", 32'(cyc), 6);
      chk("R1", "refresh counter", 32'(rrow), 32'((rc + i + 1) & 7));
      ras_n = 1'b1; wt();
      cas_n = 1'b1; wt();
    end
    chk("R1", "counter wrapped", 32'(rrow), 32'(rc));
    read_cell("R1", 0, 0);

    // R8: simultaneous fall is column-first
    rc = int'(rrow);
    cas_n = 1'b0; ras_n = 1'b0; wt();
    chk("R8", "simultaneous code", 32'(cyc), 6);
    chk("R8", "simultaneous counter", 32'(rrow), 32'((rc + 1) & 7));
    ras_n = 1'b1; cas_n = 1'b1; wt();

    // R9: hidden refresh keeps read data driven
    rc = int'(rrow);
    addr = 3'd2; ras_n = 1'b0; wt();
    addr = 3'd3; oe_n = 1'b0; cas_n = 1'b0; wt();
    ras_n = 1'b1; wt();
    chk("R9", "held over row rise", 32'(dq), 32'(mem_exp[2*8+3]));
    ras_n = 1'b0; wt();
    chk("R9", "hidden code", 32'(cyc), 7);
    chk("R9", "hidden counter", 32'(rrow), 32'((rc + 1) & 7));
    chk("R9", "hidden drive", 32'(dq_oe), 1);
    chk("R9", "hidden data", 32'(dq), 32'(mem_exp[2*8+3]));
    ras_n = 1'b1; wt();
    cas_n = 1'b1; wt();
    chk("R6", "off after hidden end", 32'(dq_oe), 0);
    oe_n = 1'b1; wt();

    // R10: self-refresh entry at the threshold and exit
    rc = int'(rrow);
    cas_n = 1'b0; wt();
    ras_n = 1'b0; wt();
    chk("R10", "short pulse code", 32'(cyc), 6);
    repeat (SC - 50) @(negedge clk);
    chk("R10", "before threshold", 32'(cyc), 6);
    repeat (100) @(negedge clk);
    chk("R10", "self code", 32'(cyc), 8);
    chk("R10", "counter once", 32'(rrow), 32'((rc + 1) & 7));
    ras_n = 1'b1; wt();
    cas_n = 1'b1; wt();
    read_cell("R10", 4, 5);
    chk("R10", "normal cycle after exit", 32'(cyc), 1);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule